// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of a page table held in memory. A start pulse hands it the virtual address, the kind of access (read or write) and the privilege of the requester (user or kernel). It also takes the base address of the first-level table, which plays the role of the page table base register. The block then fetches one entry from each level over a simple word-wide memory port. Each fetch is a one-cycle request, followed by a response that may come any number of cycles later.

The first-level entry names the frame that holds a second-level table. The second-level entry holds the physical page number and the access rights. The block reports one of three results, together with a one-cycle done pulse:
- a physical address,
- a page fault (an entry is not valid),
- a protection fault (the rights deny the access).

Only one walk is in flight at a time. A start pulse that arrives while a walk is running is dropped.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o, page_fault_o and prot_fault_o are 0, and pa_o is 0.
- R2: The first read of a walk goes to root_base_i + va[31:22] × 4, using the values of root_base_i and va_i captured at the start pulse.
- R3: If the first-level entry is valid, the second read goes to ({entry[31:12], 12'b0}) + va[21:12] × 4.
- R4: An entry's valid bit is bit 0. If the first-level entry has bit 0 clear, the walk ends with page_fault_o = 1, prot_fault_o = 0 and pa_o = 0, and it makes no second read.
- R5: If the second-level entry has bit 0 clear, the walk ends with page_fault_o = 1, prot_fault_o = 0 and pa_o = 0, whatever the rights bits hold.
- R6: A read needs bit 1 (readable) of a valid second-level entry, and a write needs bit 2 (writable). If the needed bit is missing, the walk ends with prot_fault_o = 1, page_fault_o = 0 and pa_o = 0.
- R7: A user access (is_user_i = 1) also needs bit 3 (user-accessible) of the second-level entry, or it ends in a protection fault. A kernel access ignores bit 3.
- R8: An allowed access ends with both fault flags at 0 and pa_o = {entry[31:12], va[11:0]}.
- R9: busy_o is 1 from the cycle after an accepted start up to and including the cycle of done_o. done_o is high for exactly one cycle, and busy_o is 0 in the cycle after it.
- R10: A start pulse that arrives while busy_o is 1 is ignored. The running walk's reads and its result are those of the first request.
- R11: mem_req_o is high for a single cycle for each table read. A walk makes exactly one read per level visited, whatever the response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| va_i | input | 32 | Virtual address to translate |
| is_write_i | input | 1 | 1 for a write access, 0 for a read |
| is_user_i | input | 1 | 1 for a user-mode access, 0 for kernel |
| root_base_i | input | 32 | Physical base address of the first-level table |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rsp_valid_i | input | 1 | Read data is valid this cycle |
| mem_rdata_i | input | 32 | Entry returned by memory |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle pulse: result outputs are valid |
| pa_o | output | 32 | Translated physical address (0 on a fault) |
| page_fault_o | output | 1 | An entry along the walk was not valid |
| prot_fault_o | output | 1 | The rights bits deny the access |

## Verification
A request appears on mem_req_o one cycle after the accepted start, and again one cycle after the first-level response. Each result appears one cycle after the response that decides it. The bench responds on a falling edge a chosen number of cycles after it sees a request, and it looks for the done pulse on each falling edge. It therefore reads the result in the cycle the pulse appears, and checks the idle state on the falling edge that follows. The memory model computes each entry from its address, and the expected result of each walk is derived from the same arithmetic. The sweep covers every combination of rights bits with every access kind, under several latencies and several first-level indices.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  // Control states of one translation
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE
  } walk_state_t;

  // Entry flag positions
  localparam int unsigned PTE_VALID = 0;
  localparam int unsigned PTE_READ  = 1;
  localparam int unsigned PTE_WRITE = 2;
  localparam int unsigned PTE_USER  = 3;
  localparam int unsigned PTE_FLAGS = 4;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned L1_W  = 10,
  parameter int unsigned L2_W  = 10,
  parameter int unsigned ESH   = 2
) (
  input  logic [PA_W-1:0]        root_base_i,
  input  logic [L1_W+L2_W-1:0]   vpn_i,
  input  logic [PA_W-OFF_W-1:0]  l2_frame_i,
  input  logic                   sel_l2_i,
  output logic [PA_W-1:0]        addr_o
);
  localparam int unsigned VPN_W = L1_W + L2_W;

  // table base plus index scaled to entry size
  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] base,
                                                 input logic [PA_W-1:0] idx);
    return base + (idx << ESH);
  endfunction

  logic [L1_W-1:0] l1_idx;
  logic [L2_W-1:0] l2_idx;

  assign l1_idx = vpn_i[VPN_W-1 -: L1_W];
  assign l2_idx = vpn_i[L2_W-1:0];

  always_comb begin
    if (sel_l2_i)
      addr_o = entry_addr({l2_frame_i, {OFF_W{1'b0}}}, PA_W'(l2_idx));
    else
      addr_o = entry_addr(root_base_i, PA_W'(l1_idx));
  end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import pt_walk_pkg::*;
#(
  parameter int unsigned PTE_W = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic [PTE_W-1:0]       pte_i,
  input  logic                   is_write_i,
  input  logic                   is_user_i,
  output logic                   invalid_o,
  output logic                   denied_o,
  output logic [PTE_W-OFF_W-1:0] ppn_o
);
  // rights test on a valid entry: needed access bit, plus user bit for user mode
  function automatic logic rights_denied(input logic [PTE_FLAGS-1:0] fl,
                                         input logic wr, input logic usr);
    logic need_rw;
    need_rw = wr ? fl[PTE_WRITE] : fl[PTE_READ];
    return !need_rw || (usr && !fl[PTE_USER]);
  endfunction

  logic entry_unused;
  assign entry_unused = ^pte_i[OFF_W-1:PTE_FLAGS];

  assign invalid_o = !pte_i[PTE_VALID];
  assign denied_o  = pte_i[PTE_VALID] &&
                     rights_denied(pte_i[PTE_FLAGS-1:0], is_write_i, is_user_i);
  assign ppn_o     = pte_i[PTE_W-1:OFF_W];
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import pt_walk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rsp_valid_i,
  input  logic l1_ok_i,
  output logic accept_o,
  output logic l1_cap_o,
  output logic l2_cap_o,
  output logic l1_invalid_ev_o,
  output logic sel_l2_o,
  output logic req_o,
  output logic busy_o,
  output logic done_o
);
  walk_state_t state_q, state_d;

  assign accept_o        = (state_q == ST_IDLE) && start_i;
  assign l1_cap_o        = (state_q == ST_L1_WAIT) && rsp_valid_i;
  assign l2_cap_o        = (state_q == ST_L2_WAIT) && rsp_valid_i;
  assign l1_invalid_ev_o = l1_cap_o && !l1_ok_i;
  assign sel_l2_o        = (state_q == ST_L2_REQ) || (state_q == ST_L2_WAIT);
  assign req_o           = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign busy_o          = (state_q != ST_IDLE);
  assign done_o          = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_L1_REQ;
      ST_L1_REQ:  state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (rsp_valid_i) state_d = l1_ok_i ? ST_L2_REQ : ST_DONE;
      ST_L2_REQ:  state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (rsp_valid_i) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R9: result pulse lasts one cycle and the walker is idle afterwards
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R11: each request is a single-cycle strobe
  assert_req_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  // R4: an invalid first-level entry finishes the walk at once
  assert_l1_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    l1_invalid_ev_o |=> (done_o && !req_o));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned L1_W  = 10,
  parameter int unsigned ESH   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [VA_W-1:0] va_i,
  input  logic            is_write_i,
  input  logic            is_user_i,
  input  logic [PA_W-1:0] root_base_i,
  output logic            mem_req_o,
  output logic [PA_W-1:0] mem_addr_o,
  input  logic            mem_rsp_valid_i,
  input  logic [PA_W-1:0] mem_rdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [PA_W-1:0] pa_o,
  output logic            page_fault_o,
  output logic            prot_fault_o
);
  localparam int unsigned L2_W  = VA_W - OFF_W - L1_W;
  localparam int unsigned PPN_W = PA_W - OFF_W;

  // captured request
  logic [VA_W-1:0]  va_q;
  logic             wr_q, usr_q;
  logic [PA_W-1:0]  base_q;
  logic [PPN_W-1:0] l2_frame_q;

  // registered result
  logic [PA_W-1:0]  pa_q;
  logic             pf_q, prf_q;

  // internal events
  logic accept_ev, l1_cap_ev, l2_cap_ev, l1_invalid_ev, sel_l2;
  logic pte_invalid, pte_denied;
  logic [PPN_W-1:0] pte_ppn;

  ptw_ctrl u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .rsp_valid_i     (mem_rsp_valid_i),
    .l1_ok_i         (!pte_invalid),
    .accept_o        (accept_ev),
    .l1_cap_o        (l1_cap_ev),
    .l2_cap_o        (l2_cap_ev),
    .l1_invalid_ev_o (l1_invalid_ev),
    .sel_l2_o        (sel_l2),
    .req_o           (mem_req_o),
    .busy_o          (busy_o),
    .done_o          (done_o)
  );

  ptw_addr_gen #(
    .PA_W (PA_W), .OFF_W (OFF_W), .L1_W (L1_W), .L2_W (L2_W), .ESH (ESH)
  ) u_addr (
    .root_base_i (base_q),
    .vpn_i       (va_q[VA_W-1:OFF_W]),
    .l2_frame_i  (l2_frame_q),
    .sel_l2_i    (sel_l2),
    .addr_o      (mem_addr_o)
  );

  ptw_perm_check #(.PTE_W (PA_W), .OFF_W (OFF_W)) u_perm (
    .pte_i      (mem_rdata_i),
    .is_write_i (wr_q),
    .is_user_i  (usr_q),
    .invalid_o  (pte_invalid),
    .denied_o   (pte_denied),
    .ppn_o      (pte_ppn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q       <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      base_q     <= '0;
      l2_frame_q <= '0;
    end else begin
      if (accept_ev) begin
        va_q   <= va_i;
        wr_q   <= is_write_i;
        usr_q  <= is_user_i;
        base_q <= root_base_i;
      end
      if (l1_cap_ev) l2_frame_q <= pte_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_q  <= '0;
      pf_q  <= 1'b0;
      prf_q <= 1'b0;
    end else if (l1_invalid_ev) begin
      pa_q  <= '0;
      pf_q  <= 1'b1;
      prf_q <= 1'b0;
    end else if (l2_cap_ev) begin
      pf_q  <= pte_invalid;
      prf_q <= pte_denied;
      pa_q  <= (pte_invalid || pte_denied) ? '0 : {pte_ppn, va_q[OFF_W-1:0]};
    end
  end

  assign pa_o         = pa_q;
  assign page_fault_o = pf_q;
  assign prot_fault_o = prf_q;

  // R6: the two fault kinds never appear together
  assert_fault_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(page_fault_o && prot_fault_o));

  // R5: a faulting walk yields no address
  assert_fault_no_pa_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (page_fault_o || prot_fault_o)) |-> (pa_o == '0));

  // R8: page offset passes through untouched
  assert_offset_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !page_fault_o && !prot_fault_o) |-> (pa_o[OFF_W-1:0] == va_q[OFF_W-1:0]));

  // R4: an invalid first-level entry reports a page fault
  assert_l1_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    l1_invalid_ev |=> (page_fault_o && !prot_fault_o));

  // R10: the captured request does not move while a walk runs
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(va_q) && $stable(base_q) && $stable(wr_q) && $stable(usr_q)));
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  localparam logic [31:0] ROOT = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] va_in = '0;
  logic        wr_in = 1'b0;
  logic        usr_in = 1'b0;
  logic [31:0] root_in = ROOT;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        busy_o, done_o, page_fault_o, prot_fault_o;
  logic [31:0] pa_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int lat = 0;
  int nreads = 0;
  logic [31:0] rd_addr [4];

  always #5 clk = ~clk;

  pt_walker dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start), .va_i (va_in),
    .is_write_i (wr_in), .is_user_i (usr_in), .root_base_i (root_in),
    .mem_req_o (mem_req_o), .mem_addr_o (mem_addr_o),
    .mem_rsp_valid_i (rsp_valid), .mem_rdata_i (rsp_data),
    .busy_o (busy_o), .done_o (done_o), .pa_o (pa_o),
    .page_fault_o (page_fault_o), .prot_fault_o (prot_fault_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // memory contents derived from the address
  function automatic logic [31:0] mem_model(input logic [31:0] addr);
    logic [31:0] i, t, j, ppn;
    if (addr >= ROOT && addr < ROOT + 32'd4096) begin
      i = (addr - ROOT) >> 2;
      return ((32'h400 + i) << 12) | ((i % 3 != 2) ? 32'd1 : 32'd0) | 32'h0000_0AA0;
    end
    t = addr >> 12;
    j = (addr >> 2) & 32'h3FF;
    ppn = ((t * 7 + j) ^ 32'h80000) & 32'hFFFFF;
    return (ppn << 12) | (j & 32'hF);
  endfunction

  // responder: answers each request 1+lat falling edges later
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (mem_req_o) begin
        if (nreads < 4) rd_addr[nreads] = mem_addr_o;
        nreads++;
        @(negedge clk);
        chk(!mem_req_o, "R11 req width", {31'd0, mem_req_o}, 32'd0);
        repeat (lat) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_data  = mem_model(rd_addr[(nreads - 1) % 4]);
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++;
        total++;
        $display("FAIL R9 watchdog actual=%0d expected<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic expect_walk(input logic [31:0] va, input bit wr, input bit usr,
                             output logic [31:0] pa, output bit pf, output bit prf,
                             output int nrd, output logic [31:0] a1,
                             output logic [31:0] a2, output string tag);
    int l1, j, fl;
    logic [31:0] ppn;
    l1 = int'(va >> 22);
    j  = int'((va >> 12) & 32'h3FF);
    a1 = ROOT + 32'(l1 * 4);
    pa = '0; pf = 0; prf = 0; a2 = '0;
    if (l1 % 3 == 2) begin
      pf = 1; nrd = 1; tag = "R4";
      return;
    end
    nrd = 2;
    a2 = ((32'h400 + 32'(l1)) << 12) + 32'(j * 4);
    fl = j % 16;
    if (fl % 2 == 0) begin
      pf = 1; tag = "R5";
    end else if ((wr && (fl / 4) % 2 == 0) || (!wr && (fl / 2) % 2 == 0)) begin
      prf = 1; tag = "R6";
    end else if (usr && (fl / 8) % 2 == 0) begin
      prf = 1; tag = "R7";
    end else begin
      ppn = ((32'(1024 + l1) * 7 + 32'(j)) ^ 32'h80000) & 32'hFFFFF;
      pa = (ppn << 12) | (va & 32'hFFF);
      tag = (!usr && (fl / 8) % 2 == 0) ? "R7 kernel" : "R8";
    end
  endtask

  task automatic run_walk(input logic [31:0] va, input bit wr, input bit usr,
                          input int l, input bit intrude);
    logic [31:0] epa, a1, a2;
    bit epf, eprf;
    int nrd, n;
    string tag;
    expect_walk(va, wr, usr, epa, epf, eprf, nrd, a1, a2, tag);
    lat = l;
    nreads = 0;
    start = 1'b1; va_in = va; wr_in = wr; usr_in = usr;
    @(negedge clk);
    start = 1'b0; va_in = ~va; wr_in = !wr; usr_in = !usr;
    chk(busy_o, "R9 busy after start", {31'd0, busy_o}, 32'd1);
    if (intrude) begin
      start = 1'b1; va_in = va ^ 32'h0040_1000; wr_in = !wr;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done_o && n < 200) begin
      @(negedge clk);
      n++;
      if (!done_o) chk(busy_o, "R9 busy in walk", {31'd0, busy_o}, 32'd1);
    end
    chk(done_o, "R9 done seen", {31'd0, done_o}, 32'd1);
    if (intrude) tag = {tag, " R10"};
    chk(pa_o == epa, tag, pa_o, epa);
    chk(page_fault_o == epf, tag, {31'd0, page_fault_o}, {31'd0, epf});
    chk(prot_fault_o == eprf, tag, {31'd0, prot_fault_o}, {31'd0, eprf});
    chk(nreads == nrd, "R11 read count", 32'(nreads), 32'(nrd));
    chk(rd_addr[0] == a1, "R2 first addr", rd_addr[0], a1);
    if (nrd == 2) chk(rd_addr[1] == a2, "R3 second addr", rd_addr[1], a2);
    @(negedge clk);
    chk(!done_o && !busy_o, "R9 pulse end", {30'd0, done_o, busy_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o, "R1 busy", {31'd0, busy_o}, 32'd0);
    chk(!done_o, "R1 done", {31'd0, done_o}, 32'd0);
    chk(!mem_req_o, "R1 req", {31'd0, mem_req_o}, 32'd0);
    chk(!page_fault_o && !prot_fault_o, "R1 faults",
        {30'd0, page_fault_o, prot_fault_o}, 32'd0);
    chk(pa_o == '0, "R1 pa", pa_o, 32'd0);

    // sweep: first-level index x rights bits x access kind
    for (int k = 0; k < 6; k++) begin
      for (int f = 0; f < 16; f++) begin
        for (int acc = 0; acc < 4; acc++) begin
          logic [31:0] va;
          va = (32'(k * 200 + 1) << 22) | (32'(f + 16 * k) << 12) |
               (32'(f * 37 + acc * 1000) & 32'hFFF);
          run_walk(va, acc[0], acc[1], (f + acc + k) % 3, 1'b0);
        end
      end
    end

    // start pulses during a running walk
    run_walk({10'd1, 10'd15, 12'h123}, 1'b0, 1'b1, 2, 1'b1);
    run_walk({10'd4, 10'd3, 12'hFFF}, 1'b1, 1'b0, 0, 1'b1);
    run_walk({10'd2, 10'd15, 12'h001}, 1'b0, 1'b0, 1, 1'b1);
    // extreme indices
    run_walk({10'd1023, 10'd1023, 12'hABC}, 1'b1, 1'b1, 1, 1'b0);
    run_walk({10'd0, 10'd0, 12'h000}, 1'b0, 1'b0, 0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule